// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Unit

This block is the processor-side entry logic for prioritised interrupts. Devices raise requests on fixed priority levels 1 to 7. Each request is captured in a pending latch. The unit takes a pending request only when the core reports an instruction boundary. It then asks the core to save its context and enters supervisor mode. Next it runs an interrupt acknowledge cycle on the bus, driving the level it is serving.

If a device answers within the response window, the vector number it supplies is passed on. If no device answers in time, the unit produces an autovector instead, equal to a base constant plus the level. The core uses the result to fetch the handler address. A return-from-interrupt strobe restores the previously running level. When the outermost handler returns, the processor goes back to user mode.

While a handler runs, requests at or below its level are held off. A strictly higher level may nest on top of it. A small level stack records the interrupted levels in order.

Top module: `vec_iack_unit`

## Requirements
- R1: After synchronous reset, save_req, iack_active, vec_valid, vec_auto and super_mode are 0, and iack_level, vec_num and run_level are 0.
- R2: A request held on irq_in for a single cycle stays pending until that level is acknowledged. irq_in bit i stands for level i+1.
- R3: A request is taken only in a cycle where insn_done is 1, rti is 0, and no save or acknowledge is in progress. save_req is 1 from the cycle after the take until the cycle in which save_done is sampled, and never during an acknowledge cycle.
- R4: When several levels are pending, the highest level is taken. During the acknowledge cycle, iack_level carries that level. Outside it, iack_level is 0.
- R5: In the cycle after save_done is sampled, iack_active and super_mode are 1. The acknowledge cycle begins only after a save request.
- R6: If dev_vec_valid is 1 in any acknowledge cycle, then in the next cycle vec_valid pulses for one cycle with vec_num equal to the sampled dev_vec and vec_auto 0, and iack_active is 0. dev_vec_valid is ignored outside an acknowledge cycle.
- R7: If no device answers in 8 acknowledge cycles, iack_active ends after exactly 8 cycles. Then vec_valid pulses with vec_auto 1 and vec_num equal to 24 plus the level. An answer in the 8th cycle is still accepted.
- R8: run_level shows the level of the handler in service, or 0 in user mode. A pending level equal to or below run_level is not taken. A strictly higher level is taken and nests.
- R9: rti pops the level stack, so run_level returns to the interrupted level in the next cycle. The rti that empties the stack clears super_mode. rti in user mode has no effect.
- R10: A level's pending bit is cleared when its vector is delivered. Other pending levels are kept and are taken later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 7 | Request lines, bit i = level i+1 |
| insn_done | input | 1 | Instruction boundary strobe |
| save_req | output | 1 | Request to save processor context |
| save_done | input | 1 | Context save finished |
| super_mode | output | 1 | Processor is in supervisor mode |
| iack_active | output | 1 | Interrupt acknowledge cycle in progress |
| iack_level | output | 3 | Level driven during acknowledge |
| dev_vec_valid | input | 1 | A device answers with a vector number |
| dev_vec | input | 8 | Vector number from the device |
| vec_valid | output | 1 | One-cycle strobe: vector number ready |
| vec_num | output | 8 | Vector number to fetch |
| vec_auto | output | 1 | Vector number is an autovector |
| rti | input | 1 | Return from interrupt |
| run_level | output | 3 | Level of the handler in service |

## Verification
The assertions assume that save_done and dev_vec_valid are single-cycle answers to save_req and iack_active. They also assume that rti arrives only while a handler runs. The bench drives save_done only after it sees save_req. It drives dev_vec_valid only inside an observed acknowledge window, for one cycle. It issues rti after handlers return, except for one deliberate stray rti in user mode, which the requirements say must be ignored. All inputs change two nanoseconds after the rising edge, so the properties always see stable values.

// File: rtl/iack_pkg.sv
package iack_pkg;

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_SAVE = 2'd1,
        PH_ACK  = 2'd2
    } iack_phase_e;

    function automatic int unsigned level_count(int unsigned lvl_w);
        return (1 << lvl_w) - 1;
    endfunction

endpackage

// File: rtl/iack_pend.sv
module iack_pend #(
    parameter int unsigned LVL_W = 3,
    localparam int unsigned NLVL = iack_pkg::level_count(LVL_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NLVL-1:0]  irq_in,
    input  logic             clr_en,
    input  logic [LVL_W-1:0] clr_lvl,
    output logic [LVL_W-1:0] top_lvl
);
    logic [NLVL-1:0] pend_q;
    logic [NLVL-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        for (int i = 0; i < int'(NLVL); i++) begin
            if (clr_en && (int'(clr_lvl) == i + 1)) clr_vec[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_vec) | irq_in;
    end

    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < int'(NLVL); i++) begin
            if (pend_q[i]) top_lvl = LVL_W'(i + 1);
        end
    end
endmodule

// File: rtl/iack_lvl_stack.sv
module iack_lvl_stack #(
    parameter int unsigned LVL_W = 3,
    localparam int unsigned DEPTH = iack_pkg::level_count(LVL_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [LVL_W-1:0] push_lvl,
    input  logic             pop,
    output logic [LVL_W-1:0] cur_lvl,
    output logic             empty,
    output logic             single
);
    logic [LVL_W-1:0] slot_q [DEPTH];
    logic [LVL_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < int'(DEPTH); i++) slot_q[i] <= '0;
        end else if (push) begin
            slot_q[ptr_q] <= push_lvl;
            ptr_q         <= ptr_q + LVL_W'(1);
        end else if (pop && ptr_q != '0) begin
            ptr_q <= ptr_q - LVL_W'(1);
        end
    end

    assign empty   = (ptr_q == '0);
    assign single  = (ptr_q == LVL_W'(1));
    assign cur_lvl = empty ? '0 : slot_q[ptr_q - LVL_W'(1)];
endmodule

// File: rtl/iack_seq.sv
module iack_seq
    import iack_pkg::*;
#(
    parameter int unsigned LVL_W      = 3,
    parameter int unsigned VEC_W      = 8,
    parameter int unsigned TIMEOUT    = 8,
    parameter int unsigned AUTO_BASE  = 24,
    localparam int unsigned CNT_W     = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] top_lvl,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic             stk_empty,
    input  logic             stk_single,
    input  logic             insn_done,
    input  logic             save_done,
    input  logic             dev_vec_valid,
    input  logic [VEC_W-1:0] dev_vec,
    input  logic             rti,
    output logic             save_req,
    output logic             super_mode,
    output logic             iack_active,
    output logic [LVL_W-1:0] iack_level,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_num,
    output logic             vec_auto,
    output logic             push,
    output logic [LVL_W-1:0] served,
    output logic             pop
);
    iack_phase_e      phase_q;
    logic [LVL_W-1:0] served_q;
    logic [CNT_W-1:0] cnt_q;
    logic             super_q;
    logic             vv_q, vauto_q;
    logic [VEC_W-1:0] vnum_q;

    logic take, ack_hit, ack_to, last_pop;

    assign take     = (phase_q == PH_RUN) && !rti && insn_done && (top_lvl > cur_lvl);
    assign pop      = (phase_q == PH_RUN) && rti && !stk_empty;
    assign last_pop = pop && stk_single;
    assign ack_hit  = (phase_q == PH_ACK) && dev_vec_valid;
    assign ack_to   = (phase_q == PH_ACK) && !dev_vec_valid && (cnt_q == CNT_W'(TIMEOUT - 1));
    assign push     = ack_hit || ack_to;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_RUN;
            served_q <= '0;
            cnt_q    <= '0;
            super_q  <= 1'b0;
            vv_q     <= 1'b0;
            vauto_q  <= 1'b0;
            vnum_q   <= '0;
        end else begin
            vv_q <= 1'b0;
            unique case (phase_q)
                PH_RUN: begin
                    if (last_pop) super_q <= 1'b0;
                    if (take) begin
                        served_q <= top_lvl;
                        phase_q  <= PH_SAVE;
                    end
                end
                PH_SAVE: begin
                    if (save_done) begin
                        super_q <= 1'b1;
                        cnt_q   <= '0;
                        phase_q <= PH_ACK;
                    end
                end
                PH_ACK: begin
                    if (ack_hit) begin
                        vv_q    <= 1'b1;
                        vauto_q <= 1'b0;
                        vnum_q  <= dev_vec;
                        phase_q <= PH_RUN;
                    end else if (ack_to) begin
                        vv_q    <= 1'b1;
                        vauto_q <= 1'b1;
                        vnum_q  <= VEC_W'(AUTO_BASE) + VEC_W'(served_q);
                        phase_q <= PH_RUN;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: phase_q <= PH_RUN;
            endcase
        end
    end

    assign save_req    = (phase_q == PH_SAVE);
    assign iack_active = (phase_q == PH_ACK);
    assign iack_level  = iack_active ? served_q : '0;
    assign super_mode  = super_q;
    assign vec_valid   = vv_q;
    assign vec_num     = vnum_q;
    assign vec_auto    = vauto_q;
    assign served      = served_q;
endmodule

// File: rtl/vec_iack_unit.sv
module vec_iack_unit #(
    parameter int unsigned LVL_W     = 3,
    parameter int unsigned VEC_W     = 8,
    parameter int unsigned TIMEOUT   = 8,
    parameter int unsigned AUTO_BASE = 24,
    localparam int unsigned NLVL     = iack_pkg::level_count(LVL_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NLVL-1:0]  irq_in,
    input  logic             insn_done,
    output logic             save_req,
    input  logic             save_done,
    output logic             super_mode,
    output logic             iack_active,
    output logic [LVL_W-1:0] iack_level,
    input  logic             dev_vec_valid,
    input  logic [VEC_W-1:0] dev_vec,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_num,
    output logic             vec_auto,
    input  logic             rti,
    output logic [LVL_W-1:0] run_level
);
    logic [LVL_W-1:0] top_lvl, cur_lvl, served;
    logic             push, pop, stk_empty, stk_single;

    iack_pend #(.LVL_W(LVL_W)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .clr_en  (push),
        .clr_lvl (served),
        .top_lvl (top_lvl)
    );

    iack_lvl_stack #(.LVL_W(LVL_W)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_lvl (served),
        .pop      (pop),
        .cur_lvl  (cur_lvl),
        .empty    (stk_empty),
        .single   (stk_single)
    );

    iack_seq #(
        .LVL_W     (LVL_W),
        .VEC_W     (VEC_W),
        .TIMEOUT   (TIMEOUT),
        .AUTO_BASE (AUTO_BASE)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .top_lvl       (top_lvl),
        .cur_lvl       (cur_lvl),
        .stk_empty     (stk_empty),
        .stk_single    (stk_single),
        .insn_done     (insn_done),
        .save_done     (save_done),
        .dev_vec_valid (dev_vec_valid),
        .dev_vec       (dev_vec),
        .rti           (rti),
        .save_req      (save_req),
        .super_mode    (super_mode),
        .iack_active   (iack_active),
        .iack_level    (iack_level),
        .vec_valid     (vec_valid),
        .vec_num       (vec_num),
        .vec_auto      (vec_auto),
        .push          (push),
        .served        (served),
        .pop           (pop)
    );

    assign run_level = cur_lvl;
endmodule

// File: rtl/vec_iack_unit_chk.sv
module vec_iack_unit_chk #(
    parameter int unsigned LVL_W     = 3,
    parameter int unsigned VEC_W     = 8,
    parameter int unsigned TIMEOUT   = 8,
    parameter int unsigned AUTO_BASE = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             save_req,
    input logic             super_mode,
    input logic             iack_active,
    input logic [LVL_W-1:0] iack_level,
    input logic             dev_vec_valid,
    input logic [VEC_W-1:0] dev_vec,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_num,
    input logic             vec_auto,
    input logic [LVL_W-1:0] run_level
);
    logic [15:0] ack_len_q;

    always_ff @(posedge clk) begin
        if (rst || !iack_active) ack_len_q <= '0;
        else                     ack_len_q <= ack_len_q + 16'd1;
    end

    AST_SAVE_NOT_IN_ACK: assert property (@(posedge clk) disable iff (rst)
        !(save_req && iack_active)); // R3

    AST_ACK_AFTER_SAVE: assert property (@(posedge clk) disable iff (rst)
        $rose(iack_active) |-> $past(save_req)); // R5

    AST_ACK_IN_SUPER: assert property (@(posedge clk) disable iff (rst)
        iack_active |-> super_mode); // R5

    AST_VEC_PULSE: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !vec_valid); // R6

    AST_VEC_FROM_ACK: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> ($past(iack_active) && !iack_active)); // R6

    AST_DEV_VEC_PASS: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !vec_auto) |-> (vec_num == $past(dev_vec) && $past(dev_vec_valid))); // R6

    AST_AUTO_VALUE: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && vec_auto) |-> (vec_num == VEC_W'(AUTO_BASE) + VEC_W'($past(iack_level)))); // R7

    AST_ACK_WINDOW: assert property (@(posedge clk) disable iff (rst)
        iack_active |-> (ack_len_q < 16'(TIMEOUT))); // R7

    AST_LEVEL_ABOVE_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(iack_active) |-> (iack_level > run_level)); // R8

    AST_USER_LEVEL_ZERO: assert property (@(posedge clk) disable iff (rst)
        !super_mode |-> (run_level == '0)); // R9
endmodule

bind vec_iack_unit vec_iack_unit_chk #(
    .LVL_W     (LVL_W),
    .VEC_W     (VEC_W),
    .TIMEOUT   (TIMEOUT),
    .AUTO_BASE (AUTO_BASE)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .save_req      (save_req),
    .super_mode    (super_mode),
    .iack_active   (iack_active),
    .iack_level    (iack_level),
    .dev_vec_valid (dev_vec_valid),
    .dev_vec       (dev_vec),
    .vec_valid     (vec_valid),
    .vec_num       (vec_num),
    .vec_auto      (vec_auto),
    .run_level     (run_level)
);

// File: tb/test_vec_iack_unit.sv
`timescale 1ns/1ps
module test_vec_iack_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] irq_in = '0;
    logic       insn_done = 1'b0, save_done = 1'b0, dev_vec_valid = 1'b0, rti = 1'b0;
    logic [7:0] dev_vec = '0;
    logic       save_req, super_mode, iack_active, vec_valid, vec_auto;
    logic [2:0] iack_level, run_level;
    logic [7:0] vec_num;

    int n_tests = 0, n_fail = 0, cycles = 0;
    int last_vec = -1, last_auto = -1;
    bit started = 0;

    always #4 clk = ~clk;

    vec_iack_unit i_vec_iack_unit (
        .clk(clk), .rst(rst), .irq_in(irq_in), .insn_done(insn_done),
        .save_req(save_req), .save_done(save_done), .super_mode(super_mode),
        .iack_active(iack_active), .iack_level(iack_level),
        .dev_vec_valid(dev_vec_valid), .dev_vec(dev_vec),
        .vec_valid(vec_valid), .vec_num(vec_num), .vec_auto(vec_auto),
        .rti(rti), .run_level(run_level)
    );

    // behavioural reference model
    bit [6:0] m_pend, m_clr;
    int m_phase, m_cnt, m_served, m_tl, m_cur, m_vnum;
    bit m_super, m_vv, m_vauto;
    int m_stk[$];

    always @(posedge clk) begin
        started = 1;
        cycles++;
        if (rst) begin
            m_pend = '0; m_phase = 0; m_cnt = 0; m_served = 0;
            m_super = 0; m_vv = 0; m_vauto = 0; m_vnum = 0;
            m_stk.delete();
        end else begin
            m_tl = 0;
            for (int i = 1; i <= 7; i++) if (m_pend[i-1]) m_tl = i;
            m_cur = (m_stk.size() > 0) ? m_stk[$] : 0;
            m_clr = '0;
            m_vv = 0;
            if (m_phase == 0) begin
                if (rti) begin
                    if (m_stk.size() > 0) begin
                        void'(m_stk.pop_back());
                        if (m_stk.size() == 0) m_super = 0;
                    end
                end else if (insn_done && m_tl > m_cur) begin
                    m_served = m_tl; m_phase = 1;
                end
            end else if (m_phase == 1) begin
                if (save_done) begin m_phase = 2; m_super = 1; m_cnt = 0; end
            end else begin
                if (dev_vec_valid || m_cnt == 7) begin
                    m_vv = 1;
                    m_vauto = !dev_vec_valid;
                    m_vnum = dev_vec_valid ? int'(dev_vec) : 24 + m_served;
                    m_stk.push_back(m_served);
                    m_clr[m_served-1] = 1'b1;
                    m_phase = 0;
                end else m_cnt++;
            end
            m_pend = (m_pend & ~m_clr) | irq_in;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !rst) begin
            chk("R3", "save_req", int'(save_req), int'(m_phase == 1));
            chk("R5", "iack_active", int'(iack_active), int'(m_phase == 2));
            chk("R4", "iack_level", int'(iack_level), (m_phase == 2) ? m_served : 0);
            chk("R9", "super_mode", int'(super_mode), int'(m_super));
            chk("R6", "vec_valid", int'(vec_valid), int'(m_vv));
            chk("R7", "vec_num", int'(vec_num), m_vnum);
            chk("R7", "vec_auto", int'(vec_auto), int'(m_vauto));
            chk("R8", "run_level", int'(run_level), (m_stk.size() > 0) ? m_stk[$] : 0);
            if (vec_valid) begin last_vec = int'(vec_num); last_auto = int'(vec_auto); end
        end
    end

    task automatic cyc(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic raise(logic [6:0] m);
        irq_in = m; cyc(1); irq_in = '0;
    endtask

    task automatic pulse_rti();
        rti = 1'b1; cyc(1); rti = 1'b0;
    endtask

    task automatic enter(int dly, logic [7:0] v);
        insn_done = 1'b1; cyc(1); insn_done = 1'b0;
        while (!save_req) cyc(1);
        cyc(1);
        save_done = 1'b1; cyc(1); save_done = 1'b0;
        if (dly < 8) begin
            cyc(dly);
            dev_vec_valid = 1'b1; dev_vec = v; cyc(1);
            dev_vec_valid = 1'b0; dev_vec = '0;
        end else begin
            while (!vec_valid) cyc(1);
        end
        cyc(1);
    endtask

    always @(posedge clk) begin
        if (cycles > 50000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<50000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1 reset state
        chk("R1", "save_req", int'(save_req), 0);
        chk("R1", "iack_active", int'(iack_active), 0);
        chk("R1", "vec_valid", int'(vec_valid), 0);
        chk("R1", "super_mode", int'(super_mode), 0);
        chk("R1", "run_level", int'(run_level), 0);
        chk("R1", "vec_num", int'(vec_num), 0);
        rst = 1'b0;
        cyc(2);

        // R2: one-cycle request, no boundary yet, then taken later; device answers
        raise(7'b0000100);
        cyc(5);
        chk("R3", "no take without boundary", int'(save_req), 0);
        enter(3, 8'h40);
        chk("R2", "latched level 3 served", int'(run_level), 3);
        chk("R6", "device vector", last_vec, 8'h40);
        chk("R6", "device flag", last_auto, 0);
        pulse_rti(); cyc(1);
        chk("R9", "back to user", int'(super_mode), 0);

        // R7: no answer -> autovector
        raise(7'b0010000);
        enter(8, 8'h00);
        chk("R7", "autovector level 5", last_vec, 29);
        chk("R7", "auto flag", last_auto, 1);
        pulse_rti(); cyc(1);

        // R7 boundary: answer in 8th cycle accepted
        raise(7'b0000001);
        enter(7, 8'h77);
        chk("R7", "late answer accepted", last_vec, 8'h77);
        pulse_rti(); cyc(1);

        // R4: two levels pending, highest wins; R10 lower stays pending
        raise(7'b0100010);
        cyc(1);
        enter(2, 8'h66);
        chk("R4", "highest level taken", int'(run_level), 6);
        pulse_rti(); cyc(1);
        enter(8, 8'h00);
        chk("R10", "remaining level 2 served", last_vec, 26);
        pulse_rti(); cyc(1);

        // R8 masking and nesting
        raise(7'b0000010);
        enter(1, 8'h50);
        raise(7'b0000011);
        insn_done = 1'b1; cyc(3); insn_done = 1'b0;
        chk("R8", "equal/lower masked", int'(save_req), 0);
        raise(7'b0001000);
        enter(8, 8'h00);
        chk("R8", "nested level 4", int'(run_level), 4);
        chk("R7", "nested autovector", last_vec, 28);
        pulse_rti(); cyc(1);
        chk("R9", "restored level 2", int'(run_level), 2);
        chk("R9", "still supervisor", int'(super_mode), 1);
        pulse_rti(); cyc(1);
        chk("R9", "user after last rti", int'(super_mode), 0);
        enter(0, 8'h91);
        chk("R10", "held level 2 taken", int'(run_level), 2);
        pulse_rti(); cyc(1);
        enter(8, 8'h00);
        chk("R10", "held level 1 autovector", last_vec, 25);
        pulse_rti(); cyc(1);

        // stray inputs ignored
        pulse_rti(); cyc(1);
        chk("R9", "rti in user ignored", int'(super_mode), 0);
        dev_vec_valid = 1'b1; dev_vec = 8'h33; cyc(1);
        dev_vec_valid = 1'b0; cyc(1);
        chk("R6", "stray device answer ignored", int'(vec_valid), 0);
        chk("R6", "vector unchanged", int'(vec_num), 25);
        cyc(4);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule